// File: doc/BRIEF.md
# Eight-Pin Bidirectional I/O Port with Gated Pullups

This block is a general-purpose I/O port of eight pins on a small byte-wide register bus. Three registers control it. The data latch holds the value that is driven out. The direction register chooses, pin by pin, whether the pin drives or listens. The pullup register asks for a weak pull-high on pins that listen. For each pin the block drives three controls to the pad: an output enable, an output value and a pullup enable.

Software reads the data address to see the port. Each bit of that read comes from the latch when the pin is an output and from the sampled pad level when the pin is an input. Pad levels first pass through a two-flop synchronizer. A pullup cannot fight the driver: a pullup request on a pin is ignored in hardware while that pin is set as an output, and the enable bit does not need to be cleared.

Top module: `gpio_port`

## Requirements
- R1: While reset is low, and just after it, the latch, direction and pullup registers are all 0x00, so `pad_oe`, `pad_out` and `pad_pu` are 0x00 and every register reads 0x00.
- R2: `pad_oe[i]` equals direction bit i (1 = output, 0 = input) and `pad_out` equals the data latch.
- R3: A read at offset 0x00 returns, for each bit i, latch bit i when direction bit i is 1 and the synchronized pad level of pin i when direction bit i is 0.
- R4: A write at offset 0x00 always loads the latch, whatever the direction bits are. On input pins the stored value changes neither `pad_oe` nor the read value, and it appears once the pin is switched to output.
- R5: `pad_pu[i]` is 1 only when pullup bit i is 1 and direction bit i is 0. Setting the direction bit turns the pullup off in the same cycle, with the enable bit left as it is.
- R6: The direction register is at offset 0x04 and the pullup register at offset 0x0D. Both read back exactly the value written.
- R7: A read at any offset other than 0x00, 0x04 or 0x0D returns 0x00. A write to such an offset changes no register.
- R8: A change on `pin_in` shows in a data read after two rising clock edges, and not after one.
- R9: A write takes effect on the rising edge where `bus_wr` is high. `bus_rdata` is combinational from the address and the register state while `bus_rd` is high, and it is 0x00 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pullup enable |

## Verification
Every register drives a pad output directly, so an error in any of them shows on `pad_oe`, `pad_out` or `pad_pu` in the first cycle after the write that went wrong. An error in the per-bit read selection only shows when direction, latch and pin values differ bit by bit, so the stimulus uses values with mixed bits. A synchronizer with the wrong depth shows as a data read that changes one edge early or late. A decode fault shows as a register changing after a write to a neighbouring offset, or as a stray read of an unmapped offset that is not zero.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned GPIO_WIDTH   = 8;
   localparam int unsigned GPIO_ADDR_W  = 8;
   localparam int unsigned GPIO_SYNC    = 2;
   localparam logic [7:0]  OFS_DATA     = 8'h00;
   localparam logic [7:0]  OFS_DIR      = 8'h04;
   localparam logic [7:0]  OFS_PULL     = 8'h0D;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_PULL = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_sync: WIDTH must be at least 1");
      end

      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[0] <= '0;
            end else begin
               stage_q[0] <= async_in;
            end
         end

         for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage_q[s] <= '0;
               end else begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end

         assign sync_out = stage_q[STAGES-1];

         // R8
         first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (stage_q[0] == $past(async_in)))
            else $error("first synchronizer stage missed the pad sample");
      end
   endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  pull_q
);
   logic wr_data, wr_dir, wr_pull;

   assign wr_data = wr_en && (sel == SEL_DATA);
   assign wr_dir  = wr_en && (sel == SEL_DIR);
   assign wr_pull = wr_en && (sel == SEL_PULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         pull_q  <= '0;
      end else begin
         if (wr_data) latch_q <= wdata;
         if (wr_dir)  dir_q   <= wdata;
         if (wr_pull) pull_q  <= wdata;
      end
   end

   // R9
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> (latch_q == $past(wdata)))
      else $error("data latch not loaded on its write edge");

   // R6
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (dir_q == $past(wdata)))
      else $error("direction register not loaded on its write edge");

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || sel == SEL_NONE) |=> ($stable(latch_q) && $stable(dir_q) && $stable(pull_q)))
      else $error("register changed without a mapped write");
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
   import gpio_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  reg_sel_e         sel,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pull_q,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] port_view;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign port_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (sel)
            SEL_DATA: rdata = port_view;
            SEL_DIR:  rdata = dir_q;
            SEL_PULL: rdata = pull_q;
            default:  rdata = '0;
         endcase
      end
   end

   // R7
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (rdata == '0))
      else $error("unmapped read returned nonzero data");
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int unsigned WIDTH       = GPIO_WIDTH,
   parameter int unsigned ADDR_W      = GPIO_ADDR_W,
   parameter int unsigned SYNC_STAGES = GPIO_SYNC,
   parameter logic [7:0]  DATA_OFS    = OFS_DATA,
   parameter logic [7:0]  DIR_OFS     = OFS_DIR,
   parameter logic [7:0]  PULL_OFS    = OFS_PULL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_pu
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_addr
         $error("gpio_port: ADDR_W out of range");
      end
      if (DATA_OFS == DIR_OFS || DATA_OFS == PULL_OFS || DIR_OFS == PULL_OFS) begin : g_bad_map
         $error("gpio_port: register offsets overlap");
      end
      if (int'(PULL_OFS) >= ADDR_SPAN || int'(DIR_OFS) >= ADDR_SPAN) begin : g_bad_span
         $error("gpio_port: offset beyond address space");
      end
   endgenerate

   reg_sel_e         sel;
   logic [WIDTH-1:0] latch_q, dir_q, pull_q, pin_sync;

   always_comb begin
      if (bus_addr == ADDR_W'(DATA_OFS))      sel = SEL_DATA;
      else if (bus_addr == ADDR_W'(DIR_OFS))  sel = SEL_DIR;
      else if (bus_addr == ADDR_W'(PULL_OFS)) sel = SEL_PULL;
      else                                    sel = SEL_NONE;
   end

   gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .sel     (sel),
      .wdata   (bus_wdata),
      .latch_q (latch_q),
      .dir_q   (dir_q),
      .pull_q  (pull_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   gpio_rdmux #(.WIDTH(WIDTH)) i_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (bus_rd),
      .sel      (sel),
      .latch_q  (latch_q),
      .dir_q    (dir_q),
      .pull_q   (pull_q),
      .pin_sync (pin_sync),
      .rdata    (bus_rdata)
   );

   assign pad_oe  = dir_q;
   assign pad_out = latch_q;
   assign pad_pu  = pull_q & ~dir_q;

   // R5
   pull_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_oe) == '0))
      else $error("pullup active on a driving pin");
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pad_oe, pad_out, pad_pu;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_port i_gpio_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out),
      .pad_pu    (pad_pu)
   );

   // {dir, pull, latch, pin}
   localparam logic [31:0] VEC [6] = '{
      32'h00_FF_A5_3C,
      32'hFF_FF_A5_3C,
      32'hF0_0F_5A_C3,
      32'h0F_FF_00_FF,
      32'hAA_55_FF_00,
      32'h81_7E_66_99
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      // R1: state during reset
      check("R1 oe in reset", pad_oe, 8'h00);
      check("R1 pu in reset", pad_pu, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h00, v); check("R1 data read", v, 8'h00);
      rd(8'h04, v); check("R1 dir read", v, 8'h00);
      rd(8'h0D, v); check("R1 pull read", v, 8'h00);
      check("R1 pad_out", pad_out, 8'h00);

      // vector table: R2 R3 R5
      for (int k = 0; k < 6; k++) begin
         logic [7:0] d, p, l, n;
         {d, p, l, n} = VEC[k];
         wr(8'h04, d);
         wr(8'h0D, p);
         wr(8'h00, l);
         pin_in = n;
         repeat (3) @(negedge clk);
         rd(8'h00, v); check("R3 mixed read", v, (d & l) | (~d & n));
         check("R2 pad_oe", pad_oe, d);
         check("R2 pad_out", pad_out, l);
         check("R5 pad_pu", pad_pu, p & ~d);
         rd(8'h04, v); check("R6 dir readback", v, d);
         rd(8'h0D, v); check("R6 pull readback", v, p);
      end

      // R4: latch written while inputs
      wr(8'h04, 8'h00);
      pin_in = 8'h0F;
      wr(8'h00, 8'hC6);
      repeat (2) @(negedge clk);
      rd(8'h00, v); check("R4 input read ignores latch", v, 8'h0F);
      check("R4 oe unchanged", pad_oe, 8'h00);
      wr(8'h04, 8'hFF);
      rd(8'h00, v); check("R4 stored latch appears", v, 8'hC6);

      // R5: direction overrides pullup, enable kept
      wr(8'h04, 8'h00);
      wr(8'h0D, 8'hFF);
      check("R5 pullups on", pad_pu, 8'hFF);
      wr(8'h04, 8'h3C);
      check("R5 gated by output", pad_pu, 8'hC3);
      rd(8'h0D, v); check("R5 enable kept", v, 8'hFF);

      // R7: unmapped offsets
      wr(8'h01, 8'hFF);
      wr(8'h05, 8'hAA);
      wr(8'h0C, 8'h55);
      wr(8'hFF, 8'h77);
      rd(8'h01, v); check("R7 unmapped read 01", v, 8'h00);
      rd(8'h0E, v); check("R7 unmapped read 0E", v, 8'h00);
      rd(8'h04, v); check("R7 dir untouched", v, 8'h3C);
      rd(8'h0D, v); check("R7 pull untouched", v, 8'hFF);
      check("R7 latch untouched", pad_out, 8'hC6);

      // R8: two-edge latency on input pins
      wr(8'h04, 8'h00);
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      pin_in = 8'hA5;
      @(negedge clk);
      rd(8'h00, v); check("R8 one edge: old", v, 8'h00);
      @(negedge clk);
      rd(8'h00, v); check("R8 two edges: new", v, 8'hA5);

      // R9: write edge and combinational read
      wr(8'h04, 8'hFF);
      @(negedge clk);
      bus_addr = 8'h00; bus_wdata = 8'h3C; bus_wr = 1'b1; bus_rd = 1'b1;
      #1 check("R9 before edge", bus_rdata, 8'hC6);
      @(posedge clk);
      #1 check("R9 after edge", bus_rdata, 8'h3C);
      bus_wr = 1'b0; bus_rd = 1'b0;
      #1 check("R9 rd low gives zero", bus_rdata, 8'h00);

      // R1: reset again clears everything
      @(negedge clk);
      rst_n = 1'b0;
      #1 check("R1 async reset oe", pad_oe, 8'h00);
      check("R1 async reset out", pad_out, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      rd(8'h0D, v); check("R1 pull after reset", v, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule